// File: doc/BRIEF.md
# EDO DRAM access sequencer

This block sits between a simple host port and a 256K x 16 extended-data-out DRAM. The host presents an 18-bit word address, 16-bit write data, two byte enables and a read/write flag, and holds the request until the block acknowledges it. The block splits the address into a 9-bit row and a 9-bit column and sends both over one shared 9-bit address bus. The row goes out as the row strobe falls and the column goes out as the column strobes fall. It drives separate column strobes for the upper and lower byte, a write enable and an output enable. It also drives write data with its own drive-enable flag and samples the read data bus.

Every timing interval is a whole number of clocks, found by ceiling division of a nanosecond minimum by the clock-period parameter. Writes are early writes: the write enable settles before any column strobe falls, so the memory never drives its data pins during a write. After an access the row stays open. If the host presents a request to the same row in the acknowledge cycle, that request is served as a page-mode column access. The row closes when the next request is absent, goes to another row, or when the row has been open close to its maximum allowed time.

The host contract is as follows. A request is held until `req_ack` is seen, and the next request may be presented in the acknowledge cycle itself.

Top module: `edo_seq`

## Requirements
- R1: While reset is asserted and afterwards with no request, `mem_ras_n`, both bits of `mem_cas_n`, `mem_we_n` and `mem_oe_n` are high, and `req_ack` and `mem_dq_drive` are low.
- R2: The row part `req_addr[17:9]` is on `mem_addr` when `mem_ras_n` falls. The column part `req_addr[8:0]` is on `mem_addr` when the column strobes fall.
- R3: A read asserts both column strobes with `mem_oe_n` low. `rd_data` takes the value of `mem_dq_in` present during the last cycle of the column pulse, and is valid in the acknowledge cycle.
- R4: `mem_cas_n[1]` strobes bits 15..8 and `mem_cas_n[0]` strobes bits 7..0. A write lowers only the strobes whose enable is set (`req_be[1]` upper byte, `req_be[0]` lower byte).
- R5: Random-access timing with `CLK_NS`=10 meets all of the following:
  - row-to-column strobe delay of 15 to 20 ns;
  - row strobe low for at least 30 ns;
  - row strobe high for at least 25 ns;
  - at least 65 ns between row strobe falls;
  - for reads, data sampled at least 10 ns after the column strobe falls and at least 30 ns after the row strobe falls.
- R6: In a write, `mem_we_n` is low at least one clock before a column strobe falls. `mem_oe_n` stays high while `mem_we_n` is low, and `mem_dq_drive` is high only while `mem_we_n` is low.
- R7: A same-row request presented in the acknowledge cycle is served without the row strobe rising. Successive column strobe falls are at least 12 ns apart, with at least 3 ns of column strobe high time between them.
- R8: The row strobe rises before any access to a different row, and it rises when no request is pending after an access. A column strobe is low only while the row strobe is low.
- R9: The row strobe is never low for longer than `T_RAS_MAX` ns. A long same-row burst is therefore split over several row openings.
- R10: `req_ack` is a one-clock pulse, issued once for each completed access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Registered read data |
| mem_addr | output | 9 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 2 | Column strobes, bit 1 upper byte, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Write data toward the memory |
| mem_dq_drive | output | 1 | High while write data is to be driven |
| mem_dq_in | input | 16 | Read data from the memory |

## Verification
The bench builds the block with a 10 ns clock and the fastest-grade nanosecond minimums. This makes the row-to-column delay land exactly on its 20 ns ceiling and the read pulse land exactly on the 30 ns row access limit. The maximum row-open time is cut to 200 ns, so a burst of about thirty same-row reads crosses the row-age limit several times and exercises the forced row close and reopen of a pending request. A behavioural memory model in the bench timestamps every strobe edge against these limits.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_CAS,
        ST_CP,
        ST_CLOSE,
        ST_PRE
    } edo_state_e;

    // Clock count covering a nanosecond minimum (ceiling division).
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_row_timer.sv
module edo_row_timer #(
    parameter int AGE_W   = 8,
    parameter int RAS_MIN = 3,
    parameter int CYC_MIN = 7,
    parameter int LIMIT   = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_row,
    output logic ras_min_met,
    output logic cycle_met,
    output logic near_limit
);

    logic [AGE_W-1:0] age_q;

    // Cycles since the row strobe fell; saturates at all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '1;
        end else if (open_row) begin
            age_q <= '0;
        end else if (age_q != '1) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign ras_min_met = (age_q >= AGE_W'(RAS_MIN - 1));
    assign cycle_met   = (age_q >= AGE_W'(CYC_MIN - 1));
    assign near_limit  = (age_q >= AGE_W'(LIMIT));

endmodule

// File: rtl/edo_cas_gen.sv
module edo_cas_gen #(
    parameter int NB = 2
) (
    input  logic          is_write,
    input  logic [NB-1:0] be,
    output logic [NB-1:0] cas_n
);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign cas_n[b] = is_write ? ~be[b] : 1'b0;
    end

endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_seq_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int ROW_W     = 9,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 16,
    parameter int T_RC      = 65,
    parameter int T_RP      = 25,
    parameter int T_RAS     = 30,
    parameter int T_RAS_MAX = 75000,
    parameter int T_RCD     = 15,
    parameter int T_CAC     = 10,
    parameter int T_RAC     = 30,
    parameter int T_CASW    = 5,
    parameter int T_CP      = 3,
    parameter int T_PC      = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    input  logic                                     req_write,
    input  logic [ROW_W+COL_W-1:0]                   req_addr,
    input  logic [DATA_W-1:0]                        req_wdata,
    input  logic [DATA_W/8-1:0]                      req_be,
    output logic                                     req_ack,
    output logic [DATA_W-1:0]                        rd_data,
    output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] mem_addr,
    output logic                                     mem_ras_n,
    output logic [DATA_W/8-1:0]                      mem_cas_n,
    output logic                                     mem_we_n,
    output logic                                     mem_oe_n,
    output logic [DATA_W-1:0]                        mem_dq_out,
    output logic                                     mem_dq_drive,
    input  logic [DATA_W-1:0]                        mem_dq_in
);

    localparam int NB        = DATA_W / 8;
    localparam int MA_W      = imax(ROW_W, COL_W);
    localparam int N_RCD     = imax(cdiv(T_RCD, CLK_NS), 1);
    localparam int N_RD      = imax(imax(cdiv(T_CAC, CLK_NS), cdiv(T_RAC, CLK_NS) - N_RCD), 1);
    localparam int N_WR      = imax(cdiv(T_CASW, CLK_NS), 1);
    localparam int N_CASMIN  = (N_RD < N_WR) ? N_RD : N_WR;
    localparam int N_CP      = imax(imax(cdiv(T_CP, CLK_NS), cdiv(T_PC, CLK_NS) - N_CASMIN), 1);
    localparam int N_RAS     = imax(cdiv(T_RAS, CLK_NS), 1);
    localparam int N_RP      = imax(cdiv(T_RP, CLK_NS), 1);
    localparam int N_RC      = imax(cdiv(T_RC, CLK_NS), N_RAS + N_RP);
    localparam int N_RAS_MAX = T_RAS_MAX / CLK_NS;
    localparam int N_MARGIN  = imax(N_RD, N_WR) + N_CP + 3;
    localparam int N_LIM     = imax(N_RAS_MAX - N_MARGIN, N_RAS);
    localparam int AGE_W     = $clog2(imax(N_RAS_MAX, N_RC) + 2);
    localparam int ST_W      = $clog2(imax(imax(N_RCD, N_RD), imax(imax(N_WR, N_CP), N_RP)) + 1) + 1;

    typedef struct packed {
        edo_state_e       state;
        logic [ST_W-1:0]  cnt;
        logic             ras_n;
        logic [NB-1:0]    cas_n;
        logic             we_n;
        logic             oe_n;
        logic [MA_W-1:0]  ma;
        logic [DATA_W-1:0] dq_out;
        logic             dq_oe;
        logic             ack;
        logic [DATA_W-1:0] rd_data;
        logic             wr;
        logic [NB-1:0]    be;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state:   ST_IDLE,
        cnt:     '0,
        ras_n:   1'b1,
        cas_n:   '1,
        we_n:    1'b1,
        oe_n:    1'b1,
        ma:      '0,
        dq_out:  '0,
        dq_oe:   1'b0,
        ack:     1'b0,
        rd_data: '0,
        wr:      1'b0,
        be:      '0,
        row:     '0,
        col:     '0
    };

    seq_t q, d;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             open_row;
    logic             ras_min_met, cycle_met, near_limit;
    logic             gen_wr;
    logic [NB-1:0]    gen_be;
    logic [NB-1:0]    cas_sel_n;
    logic             page_hit;
    logic [ST_W-1:0]  cas_last;

    assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    edo_row_timer #(
        .AGE_W  (AGE_W),
        .RAS_MIN(N_RAS),
        .CYC_MIN(N_RC),
        .LIMIT  (N_LIM)
    ) u_row_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_row   (open_row),
        .ras_min_met(ras_min_met),
        .cycle_met  (cycle_met),
        .near_limit (near_limit)
    );

    // Strobe pattern for the access about to start: the latched first access
    // of a row, or the live request when continuing in page mode.
    assign gen_wr = (q.state == ST_CP) ? req_write : q.wr;
    assign gen_be = (q.state == ST_CP) ? req_be    : q.be;

    edo_cas_gen #(.NB(NB)) u_cas_gen (
        .is_write(gen_wr),
        .be      (gen_be),
        .cas_n   (cas_sel_n)
    );

    assign page_hit = req_valid && (req_row == q.row) && !near_limit;
    assign cas_last = q.wr ? ST_W'(N_WR - 1) : ST_W'(N_RD - 1);

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        open_row = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state  = ST_RCD;
                    d.cnt    = '0;
                    d.ras_n  = 1'b0;
                    d.ma     = MA_W'(req_row);
                    d.we_n   = ~req_write;
                    d.dq_oe  = req_write;
                    d.dq_out = req_wdata;
                    d.wr     = req_write;
                    d.be     = req_be;
                    d.row    = req_row;
                    d.col    = req_col;
                    open_row = 1'b1;
                end
            end
            ST_RCD: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == ST_W'(N_RCD - 1)) begin
                    d.state = ST_CAS;
                    d.cnt   = '0;
                    d.ma    = MA_W'(q.col);
                    d.cas_n = cas_sel_n;
                    d.oe_n  = q.wr;
                end
            end
            ST_CAS: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == cas_last) begin
                    d.state = ST_CP;
                    d.cnt   = '0;
                    d.cas_n = '1;
                    d.oe_n  = 1'b1;
                    d.we_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    d.ack   = 1'b1;
                    if (!q.wr) begin
                        d.rd_data = mem_dq_in;
                    end
                end
            end
            ST_CP: begin
                if (q.cnt != ST_W'(N_CP - 1)) begin
                    d.cnt = q.cnt + 1'b1;
                end
                d.we_n   = ~(page_hit & req_write);
                d.dq_oe  = page_hit & req_write;
                d.dq_out = req_wdata;
                if (q.cnt == ST_W'(N_CP - 1)) begin
                    if (page_hit && (q.we_n == ~req_write)) begin
                        d.state = ST_CAS;
                        d.cnt   = '0;
                        d.wr    = req_write;
                        d.be    = req_be;
                        d.col   = req_col;
                        d.ma    = MA_W'(req_col);
                        d.cas_n = cas_sel_n;
                        d.oe_n  = req_write;
                    end else if (!page_hit) begin
                        d.state = ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                if (ras_min_met) begin
                    d.ras_n = 1'b1;
                    d.state = ST_PRE;
                    d.cnt   = '0;
                end
            end
            ST_PRE: begin
                if (q.cnt != ST_W'(N_RP - 1)) begin
                    d.cnt = q.cnt + 1'b1;
                end else if (cycle_met) begin
                    d.state = ST_IDLE;
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ack      = q.ack;
    assign rd_data      = q.rd_data;
    assign mem_addr     = q.ma;
    assign mem_ras_n    = q.ras_n;
    assign mem_cas_n    = q.cas_n;
    assign mem_we_n     = q.we_n;
    assign mem_oe_n     = q.oe_n;
    assign mem_dq_out   = q.dq_out;
    assign mem_dq_drive = q.dq_oe;

endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
    parameter int ROW_W     = 9,
    parameter int COL_W     = 9,
    parameter int NB        = 2,
    parameter int MA_W      = 9,
    parameter int CLK_NS    = 10,
    parameter int T_RAS_MAX = 75000
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ROW_W+COL_W-1:0] req_addr,
    input logic                   req_ack,
    input logic [MA_W-1:0]        mem_addr,
    input logic                   mem_ras_n,
    input logic [NB-1:0]          mem_cas_n,
    input logic                   mem_we_n,
    input logic                   mem_oe_n,
    input logic                   mem_dq_drive
);

    localparam int RAS_MAX_CYC = T_RAS_MAX / CLK_NS;
    localparam int LOW_W       = $clog2(RAS_MAX_CYC + 2) + 1;

    logic             cas_idle;
    logic [LOW_W-1:0] ras_low_cnt;

    assign cas_idle = &mem_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_low_cnt <= '0;
        end else if (mem_ras_n) begin
            ras_low_cnt <= '0;
        end else if (ras_low_cnt != '1) begin
            ras_low_cnt <= ras_low_cnt + 1'b1;
        end
    end

    // R2
    row_on_ras_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (mem_addr == MA_W'($past(req_addr[ROW_W+COL_W-1:COL_W]))));

    // R3
    read_both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_cas_n == '0));

    // R6
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_idle) && !mem_we_n) |-> $past(!mem_we_n));

    // R6
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R6
    drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> !mem_we_n);

    // R8
    cas_inside_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_idle |-> !mem_ras_n);

    // R9
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low_cnt <= LOW_W'(RAS_MAX_CYC));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

endmodule

bind edo_seq edo_seq_chk #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .NB       (DATA_W / 8),
    .MA_W     ((ROW_W > COL_W) ? ROW_W : COL_W),
    .CLK_NS   (CLK_NS),
    .T_RAS_MAX(T_RAS_MAX)
) i_edo_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_addr    (req_addr),
    .req_ack     (req_ack),
    .mem_addr    (mem_addr),
    .mem_ras_n   (mem_ras_n),
    .mem_cas_n   (mem_cas_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_drive(mem_dq_drive)
);

// File: tb/test_edo_seq.sv
`timescale 1ns/1ps
module test_edo_seq;

    localparam int CLK_PERIOD = 10;
    localparam int RAS_MAX_NS = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ack;
    logic [15:0] rd_data;
    logic [8:0]  mem_addr;
    logic        mem_ras_n;
    logic [1:0]  mem_cas_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_drive;
    logic [15:0] mem_dq_in;

    int errors = 0;
    int checks = 0;
    int ras_falls = 0;
    int acks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edo_seq #(
        .CLK_NS   (CLK_PERIOD),
        .T_RAS_MAX(RAS_MAX_NS)
    ) i_edo_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .req_ack     (req_ack),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .mem_ras_n   (mem_ras_n),
        .mem_cas_n   (mem_cas_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_drive(mem_dq_drive),
        .mem_dq_in   (mem_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] seed(input logic [17:0] a);
        return 16'(a * 7) ^ 16'h5A5A;
    endfunction

    // ---------------- behavioural memory model ----------------
    logic [15:0] mem [int];
    logic [15:0] exp_mem [int];

    function automatic logic [15:0] mem_get(input logic [17:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : seed(a);
    endfunction

    function automatic logic [15:0] exp_get(input logic [17:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : seed(a);
    endfunction

    logic        cas_any_n;
    logic [8:0]  cap_row = '0;
    logic [8:0]  cap_col = '0;
    logic [1:0]  cap_cas = '1;
    logic [15:0] model_q = '0;
    bit          row_open = 0;
    bit          cas_low = 0;
    bit          first_cas = 0;
    bit          cur_write = 0;
    realtime     t_ras_fall = -1000.0;
    realtime     t_ras_rise = -1000.0;
    realtime     t_cas_fall = -1000.0;
    realtime     t_cas_rise = -1000.0;
    realtime     t_we_fall = -1000.0;

    assign cas_any_n = &mem_cas_n;
    assign mem_dq_in = (!cas_any_n && !mem_oe_n && mem_we_n) ? model_q : 16'hBAD0;

    always @(negedge mem_we_n) t_we_fall = $realtime;

    always @(negedge mem_ras_n) begin
        // R5 precharge and cycle time
        check(($realtime - t_ras_rise) >= 25.0, "R5 row strobe high time", int'($realtime - t_ras_rise), 25);
        check(($realtime - t_ras_fall) >= 65.0, "R5 row cycle time", int'($realtime - t_ras_fall), 65);
        t_ras_fall = $realtime;
        cap_row    = mem_addr;
        row_open   = 1;
        first_cas  = 1;
        ras_falls++;
    end

    always @(posedge mem_ras_n) begin
        if (row_open) begin
            check(($realtime - t_ras_fall) >= 30.0, "R5 row strobe low time", int'($realtime - t_ras_fall), 30);
            check(($realtime - t_ras_fall) <= real'(RAS_MAX_NS), "R9 row strobe max low",
                  int'($realtime - t_ras_fall), RAS_MAX_NS);
            row_open   = 0;
            t_ras_rise = $realtime;
        end
    end

    always @(negedge cas_any_n) begin
        logic [17:0] a;
        logic [15:0] v;
        check(!mem_ras_n, "R8 column strobe inside row", int'(mem_ras_n), 0);
        if (first_cas) begin
            check(($realtime - t_ras_fall) >= 15.0 && ($realtime - t_ras_fall) <= 20.0,
                  "R5 row-to-column delay", int'($realtime - t_ras_fall), 20);
        end else begin
            check(($realtime - t_cas_fall) >= 12.0, "R7 page cycle", int'($realtime - t_cas_fall), 12);
            check(($realtime - t_cas_rise) >= 3.0, "R7 column precharge", int'($realtime - t_cas_rise), 3);
        end
        first_cas  = 0;
        t_cas_fall = $realtime;
        cas_low    = 1;
        cap_col    = mem_addr;
        cap_cas    = mem_cas_n;
        cur_write  = !mem_we_n;
        a = {cap_row, mem_addr};
        if (!mem_we_n) begin
            check(t_we_fall < $realtime, "R6 write enable before column strobe", int'(t_we_fall), int'($realtime));
            check(mem_oe_n == 1'b1, "R6 output enable high in write", int'(mem_oe_n), 1);
            check(mem_dq_drive == 1'b1, "R6 data driven in write", int'(mem_dq_drive), 1);
            v = mem_get(a);
            if (!mem_cas_n[1]) v[15:8] = mem_dq_out[15:8];
            if (!mem_cas_n[0]) v[7:0]  = mem_dq_out[7:0];
            mem[int'(a)] = v;
        end else begin
            check(mem_cas_n == 2'b00, "R3 both strobes on read", int'(mem_cas_n), 0);
        end
        model_q = mem_get(a);
    end

    always @(posedge cas_any_n) begin
        if (cas_low) begin
            if (!cur_write) begin
                check(($realtime - t_cas_fall) >= 10.0, "R5 column access time", int'($realtime - t_cas_fall), 10);
                check(($realtime - t_ras_fall) >= 30.0, "R5 row access time", int'($realtime - t_ras_fall), 30);
            end
            cas_low    = 0;
            t_cas_rise = $realtime;
        end
    end

    // R10: acknowledge is a single-cycle pulse
    bit ack_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ack && ack_prev) check(0, "R10 acknowledge longer than one clock", 2, 1);
            if (req_ack) acks++;
        end
        ack_prev = req_ack;
    end

    // ---------------- host tasks ----------------
    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] v;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        do @(negedge clk); while (!req_ack);
        if (wr) begin
            v = exp_get(a);
            if (be[1]) v[15:8] = d[15:8];
            if (be[0]) v[7:0]  = d[7:0];
            exp_mem[int'(a)] = v;
        end
    endtask

    task automatic rd_chk(input logic [17:0] a, input string tag);
        access(1'b0, a, 16'h0, 2'b00);
        check(rd_data == exp_get(a), tag, int'(rd_data), int'(exp_get(a)));
        check({cap_row, cap_col} == a, "R2 row and column split", int'({cap_row, cap_col}), int'(a));
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} == 5'b11111, "R1 strobes idle in reset",
              int'({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}), 5'h1f);
        check({req_ack, mem_dq_drive} == 2'b00, "R1 ack and drive low in reset", int'({req_ack, mem_dq_drive}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} == 5'b11111, "R1 strobes idle without request",
              int'({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}), 5'h1f);
    endtask

    task automatic t_single();
        access(1'b1, 18'h2_3456, 16'hC0DE, 2'b11);
        check(cap_cas == 2'b00, "R4 full write lowers both strobes", int'(cap_cas), 0);
        check({cap_row, cap_col} == 18'h2_3456, "R2 write address split", int'({cap_row, cap_col}), 18'h23456);
        go_idle();
        rd_chk(18'h2_3456, "R3 single read after write");
        go_idle();
        rd_chk(18'h3_FFFF, "R3 read of untouched word");
        go_idle();
        rd_chk(18'h0_0000, "R3 read at address zero");
        go_idle();
    endtask

    task automatic t_bytes();
        access(1'b1, 18'h0_1200, 16'h1111, 2'b11);
        go_idle();
        access(1'b1, 18'h0_1200, 16'hAB00, 2'b10);
        check(cap_cas == 2'b01, "R4 upper-only write strobe", int'(cap_cas), 1);
        go_idle();
        rd_chk(18'h0_1200, "R4 upper byte merged");
        go_idle();
        access(1'b1, 18'h0_1200, 16'h00CD, 2'b01);
        check(cap_cas == 2'b10, "R4 lower-only write strobe", int'(cap_cas), 2);
        go_idle();
        rd_chk(18'h0_1200, "R4 lower byte merged");
        go_idle();
    endtask

    task automatic t_page();
        int f0, a0;
        f0 = ras_falls;
        a0 = acks;
        access(1'b1, 18'h0_0601, 16'h1234, 2'b11);
        access(1'b1, 18'h0_0602, 16'h5678, 2'b11);
        rd_chk(18'h0_0601, "R7 page read first column");
        rd_chk(18'h0_0602, "R7 page read second column");
        access(1'b1, 18'h0_0601, 16'hFF99, 2'b01);
        rd_chk(18'h0_0601, "R7 page read after byte write");
        check(ras_falls - f0 == 1, "R7 burst kept one row open", ras_falls - f0, 1);
        go_idle();
        check(acks - a0 == 6, "R10 one acknowledge per access", acks - a0, 6);
    endtask

    task automatic t_row_change();
        int f0;
        f0 = ras_falls;
        rd_chk(18'h0_0A10, "R8 read row A");
        rd_chk(18'h0_0C10, "R8 read row B");
        rd_chk(18'h0_0A11, "R8 read row A again");
        check(ras_falls - f0 == 3, "R8 row change reopens row", ras_falls - f0, 3);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(mem_ras_n == 1'b1, "R8 row closed with no request", int'(mem_ras_n), 1);
        go_idle();
    endtask

    task automatic t_long_burst();
        int f0;
        f0 = ras_falls;
        for (int i = 0; i < 30; i++) begin
            rd_chk({9'h05, 9'(i * 3)}, "R9 long burst read data");
        end
        check(ras_falls - f0 >= 2, "R9 long burst split over rows", ras_falls - f0, 2);
        go_idle();
    endtask

    bit done = 0;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            check(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_bytes();
        t_page();
        t_row_change();
        t_long_burst();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule